// File: doc/BRIEF.md
# Indirect SDRAM Controller Configuration Register File

This block holds the configuration and status registers of an SDRAM controller and reaches them through only two locations on a simple register bus. A pointer register chooses an internal offset. A window register then reads or writes whatever register that offset names. The block stores the controller's error-address, configuration, status, refresh, power-management and ECC registers. Each register applies its own write mask, forced bits or side effects.

Two outputs go to the rest of the controller. The first is a global memory enable, taken from the top bit of the configuration register. The second is a level interrupt that stays high while the ECC error-status register is nonzero. Writes to the four bank configuration offsets are not stored here. They go to a separate bank decoder as a one-cycle strobe with a bank index. Reads of those offsets return the data that the decoder supplies for the indexed bank.

The enable is kept by a two-state machine, `sdram_cfg_enable_fsm`, with the states ST_OFF (memory disabled, the reset state) and ST_ON (memory enabled). There are two transitions:
- T_ENABLE moves from ST_OFF to ST_ON on a configuration write with bit 31 set.
- T_DISABLE moves from ST_ON to ST_OFF on a configuration write with bit 31 clear.

In any other case the machine stays in its current state. T_ENABLE clears status bit 31 and T_DISABLE sets it.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: A bus write to register number 0x10 loads the full 32-bit pointer, and a read of 0x10 returns the stored pointer.
- R2: A read of any bus register number other than 0x10 and 0x11 returns zero, and a write to such a number changes no internal register.
- R3: The error-status offsets 0x00 and 0x08 clear every bit written as 1. No error source sets them, so they always read zero.
- R4: The error-address offset 0x10 stores all 32 written bits and reads them back.
- R5: The configuration offset 0x20 keeps bits 31:21 of a write and reads bits 20:0 as zero. Its reset value is 0x00800000.
- R6: The enable FSM starts in ST_OFF. T_ENABLE drives mem_enable high and clears status bit 31. T_DISABLE drives mem_enable low and sets status bit 31. A configuration write that does not change bit 31 leaves both unchanged. The change takes effect at the clock edge that captures the write.
- R7: When configuration bit 30 goes from 0 to 1, status bit 30 is set. When it goes from 1 to 0, status bit 30 is cleared.
- R8: The status offset 0x24 is read-only, and all its bits other than 31 and 30 read zero.
- R9: The refresh offset 0x30 stores the write ANDed with 0x3FF80000 and resets to 0x05F00000. The ECC configuration offset 0x94 stores the write ANDed with 0x00F00000 and resets to zero.
- R10: The power-management offset 0x34 keeps bits 31:27 of a write, always reads bits 26:22 as ones and reads bits 21:0 as zero. Its reset value is 0x07C00000.
- R11: A read of the timing offset 0x80, or of any offset not listed in these requirements, returns 0xFFFFFFFF.
- R12: The ECC error-status offset 0x98 stores the write ANDed with 0xFFF0F000 and resets to zero. ecc_irq is high exactly while this register is nonzero.
- R13: After reset, the pointer, error-address and status registers read zero, and ecc_irq and mem_enable are low.
- R14: A window write to offset 0x40 + 4*k (k below NBANK) pulses bank_we in that same cycle. bank_idx equals k and bank_wdata equals the written data. A window read of that offset returns bank_rdata, and bank_idx shows k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_num | input | BUS_AW | Bus register number |
| bus_wdata | input | 32 | Bus write data |
| bus_we | input | 1 | Bus write enable |
| bus_rdata | output | 32 | Bus read data, combinational from bus_num |
| ecc_irq | output | 1 | ECC error interrupt (level) |
| mem_enable | output | 1 | Global memory enable |
| bank_we | output | 1 | Bank configuration write strobe |
| bank_idx | output | BIW | Bank selected by the pointer |
| bank_wdata | output | 32 | Bank configuration write data |
| bank_rdata | input | 32 | Bank configuration read data from the decoder |

## Verification
The assertions assume that bus_we is a one-cycle qualifier sampled at the clock edge. They also assume that bus_num and bus_wdata are stable around that edge. Finally, they assume that bank_rdata depends only on bank_idx, so that a bank read is well defined.

The bench changes inputs only at falling edges and holds each write for exactly one rising edge. It draws the pointer from a fixed list of offsets that mixes mapped, timing, bank and unmapped ones. It forces a zero write data value often enough that the interrupt falls as well as rises.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

    localparam int DW = 32;

    // internal offsets selected through the pointer register
    localparam logic [DW-1:0] OFF_ESR_A  = 32'h00;
    localparam logic [DW-1:0] OFF_ESR_B  = 32'h08;
    localparam logic [DW-1:0] OFF_EADDR  = 32'h10;
    localparam logic [DW-1:0] OFF_CFG    = 32'h20;
    localparam logic [DW-1:0] OFF_STAT   = 32'h24;
    localparam logic [DW-1:0] OFF_RFSH   = 32'h30;
    localparam logic [DW-1:0] OFF_PWR    = 32'h34;
    localparam logic [DW-1:0] OFF_BANK0  = 32'h40;
    localparam logic [DW-1:0] OFF_TIM    = 32'h80;
    localparam logic [DW-1:0] OFF_ECFG   = 32'h94;
    localparam logic [DW-1:0] OFF_EESR   = 32'h98;

    localparam logic [DW-1:0] RFSH_MASK  = 32'h3FF8_0000;
    localparam logic [DW-1:0] RFSH_RST   = 32'h05F0_0000;
    localparam logic [DW-1:0] EESR_MASK  = 32'hFFF0_F000;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_ESR, SEL_EADDR, SEL_CFG, SEL_STAT, SEL_RFSH,
        SEL_PWR, SEL_BANK, SEL_TIM, SEL_ECFG, SEL_EESR
    } win_sel_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } en_state_e;

endpackage

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode
    import sdram_cfg_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BIW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [DW-1:0]  ptr,
    output win_sel_e       sel,
    output logic [BIW-1:0] bidx
);

    always_comb begin
        sel  = SEL_NONE;
        bidx = '0;
        case (ptr)
            OFF_ESR_A, OFF_ESR_B: sel = SEL_ESR;
            OFF_EADDR:            sel = SEL_EADDR;
            OFF_CFG:              sel = SEL_CFG;
            OFF_STAT:             sel = SEL_STAT;
            OFF_RFSH:             sel = SEL_RFSH;
            OFF_PWR:              sel = SEL_PWR;
            OFF_TIM:              sel = SEL_TIM;
            OFF_ECFG:             sel = SEL_ECFG;
            OFF_EESR:             sel = SEL_EESR;
            default:              sel = SEL_NONE;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            if (ptr == OFF_BANK0 + DW'(4 * b)) begin
                sel  = SEL_BANK;
                bidx = BIW'(b);
            end
        end
    end

endmodule

// File: rtl/sdram_cfg_enable_fsm.sv
module sdram_cfg_enable_fsm
    import sdram_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_en_bit,
    output logic enabled,
    output logic go_on,
    output logic go_off
);

    en_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (cfg_wr && cfg_en_bit)  state_d = ST_ON;   // T_ENABLE
            ST_ON:  if (cfg_wr && !cfg_en_bit) state_d = ST_OFF;  // T_DISABLE
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        enabled = 1'b0;
        go_on   = 1'b0;
        go_off  = 1'b0;
        unique case (state_q)
            ST_OFF: go_on = (state_d == ST_ON);
            ST_ON: begin
                enabled = 1'b1;
                go_off  = (state_d == ST_OFF);
            end
        endcase
    end

endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
    import sdram_cfg_pkg::*;
#(
    parameter int BUS_AW = 10,
    parameter logic [BUS_AW-1:0] PTR_NUM = 'h10,
    parameter logic [BUS_AW-1:0] WIN_NUM = 'h11,
    parameter int NBANK = 4,
    localparam int BIW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_num,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    output logic              ecc_irq,
    output logic              mem_enable,
    output logic              bank_we,
    output logic [BIW-1:0]    bank_idx,
    output logic [DW-1:0]     bank_wdata,
    input  logic [DW-1:0]     bank_rdata
);

    logic [DW-1:0] ptr_q, eaddr_q, rfsh_q, eesr_q;
    logic [9:0]    cfg_q;      // configuration bits 30:21
    logic [4:0]    pwr_q;      // power-management bits 31:27
    logic [3:0]    ecfg_q;     // ECC configuration bits 23:20
    logic          st31_q, st30_q;
    logic          win_we, go_on, go_off;
    win_sel_e      sel;
    logic [DW-1:0] win_rdata;

    assign win_we = bus_we && (bus_num == WIN_NUM);

    sdram_cfg_decode #(.NBANK(NBANK)) u_dec (
        .ptr  (ptr_q),
        .sel  (sel),
        .bidx (bank_idx)
    );

    sdram_cfg_enable_fsm u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (win_we && (sel == SEL_CFG)),
        .cfg_en_bit (bus_wdata[31]),
        .enabled    (mem_enable),
        .go_on      (go_on),
        .go_off     (go_off)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            eaddr_q <= '0;
            cfg_q   <= 10'b00_0000_0100;
            rfsh_q  <= RFSH_RST;
            pwr_q   <= '0;
            ecfg_q  <= '0;
            eesr_q  <= '0;
            st30_q  <= 1'b0;
            st31_q  <= 1'b0;
        end else begin
            if (bus_we && (bus_num == PTR_NUM)) ptr_q <= bus_wdata;
            if (go_on)       st31_q <= 1'b0;
            else if (go_off) st31_q <= 1'b1;
            if (win_we) begin
                case (sel)
                    SEL_EADDR: eaddr_q <= bus_wdata;
                    SEL_CFG: begin
                        cfg_q <= bus_wdata[30:21];
                        if (!cfg_q[9] && bus_wdata[30])      st30_q <= 1'b1;
                        else if (cfg_q[9] && !bus_wdata[30]) st30_q <= 1'b0;
                    end
                    SEL_RFSH: rfsh_q <= bus_wdata & RFSH_MASK;
                    SEL_PWR:  pwr_q  <= bus_wdata[31:27];
                    SEL_ECFG: ecfg_q <= bus_wdata[23:20];
                    SEL_EESR: eesr_q <= bus_wdata & EESR_MASK;
                    default: ;
                endcase
            end
        end
    end

    assign ecc_irq    = (eesr_q != '0);
    assign bank_we    = win_we && (sel == SEL_BANK);
    assign bank_wdata = bus_wdata;

    always_comb begin
        case (sel)
            SEL_ESR:   win_rdata = '0;
            SEL_EADDR: win_rdata = eaddr_q;
            SEL_CFG:   win_rdata = {mem_enable, cfg_q, 21'b0};
            SEL_STAT:  win_rdata = {st31_q, st30_q, 30'b0};
            SEL_RFSH:  win_rdata = rfsh_q;
            SEL_PWR:   win_rdata = {pwr_q, 5'h1F, 22'b0};
            SEL_BANK:  win_rdata = bank_rdata;
            SEL_ECFG:  win_rdata = {8'b0, ecfg_q, 20'b0};
            SEL_EESR:  win_rdata = eesr_q;
            default:   win_rdata = '1;
        endcase
    end

    always_comb begin
        if (bus_num == PTR_NUM)      bus_rdata = ptr_q;
        else if (bus_num == WIN_NUM) bus_rdata = win_rdata;
        else                         bus_rdata = '0;
    end

endmodule

// File: rtl/sdram_cfg_chk.sv
module sdram_cfg_chk
    import sdram_cfg_pkg::*;
#(
    parameter int BUS_AW = 10,
    parameter logic [BUS_AW-1:0] WIN_NUM = 'h11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_num,
    input logic              bus_we,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     ptr_q,
    input logic [1:0]        status_bits,
    input logic              ecc_irq,
    input logic              mem_enable,
    input logic              bank_we
);

    logic win_wr;
    assign win_wr = bus_we && (bus_num == WIN_NUM);

    // R12
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && ptr_q == OFF_EESR) |=> (ecc_irq == (($past(bus_wdata) & EESR_MASK) != '0)));

    // R8
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && ptr_q == OFF_STAT) |=> $stable(status_bits));

    // R6
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_enable) |-> !status_bits[1]);

    // R6
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_enable) |-> status_bits[1]);

    // R14
    bank_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> win_wr);

endmodule

bind sdram_cfg_regfile sdram_cfg_chk #(.BUS_AW(BUS_AW), .WIN_NUM(WIN_NUM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_num     (bus_num),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .ptr_q       (ptr_q),
    .status_bits ({st31_q, st30_q}),
    .ecc_irq     (ecc_irq),
    .mem_enable  (mem_enable),
    .bank_we     (bank_we)
);

// File: tb/tb_sdram_cfg_regfile.sv
`timescale 1ns/1ps
module tb_sdram_cfg_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_num = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        ecc_irq, mem_enable, bank_we;
    logic [1:0]  bank_idx;
    logic [31:0] bank_wdata, bank_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [31:0] m_ptr, m_ear, m_cfg, m_stat, m_rfsh, m_pwr, m_ecfg, m_eesr;

    always #2.5 clk = ~clk;

    assign bank_rdata = 32'hB000_0000 | {30'b0, bank_idx};

    sdram_cfg_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_num(bus_num), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ecc_irq(ecc_irq),
        .mem_enable(mem_enable), .bank_we(bank_we), .bank_idx(bank_idx),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish (act hung, exp done)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_win(input logic [31:0] off);
        case (off)
            32'h00, 32'h08: return 32'h0;
            32'h10: return m_ear;
            32'h20: return m_cfg;
            32'h24: return m_stat;
            32'h30: return m_rfsh;
            32'h34: return m_pwr;
            32'h40, 32'h44, 32'h48, 32'h4C: return 32'hB000_0000 | ((off - 32'h40) >> 2);
            32'h94: return m_ecfg;
            32'h98: return m_eesr;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic model_win_write(input logic [31:0] off, input logic [31:0] v);
        logic [31:0] nc;
        case (off)
            32'h10: m_ear = v;
            32'h20: begin
                nc = v & 32'hFFE0_0000;
                if (!m_cfg[31] && nc[31]) m_stat[31] = 1'b0;
                else if (m_cfg[31] && !nc[31]) m_stat[31] = 1'b1;
                if (!m_cfg[30] && nc[30]) m_stat[30] = 1'b1;
                else if (m_cfg[30] && !nc[30]) m_stat[30] = 1'b0;
                m_cfg = nc;
            end
            32'h30: m_rfsh = v & 32'h3FF8_0000;
            32'h34: m_pwr = (v & 32'hF800_0000) | 32'h07C0_0000;
            32'h94: m_ecfg = v & 32'h00F0_0000;
            32'h98: m_eesr = v & 32'hFFF0_F000;
            default: ;
        endcase
    endtask

    task automatic bus_wr(input logic [9:0] num, input logic [31:0] d);
        @(negedge clk);
        bus_num = num; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (num == 10'h10) m_ptr = d;
        if (num == 10'h11) model_win_write(m_ptr, d);
    endtask

    task automatic bus_rd(input logic [9:0] num, output logic [31:0] d);
        @(negedge clk);
        bus_num = num; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic win_check(input string tag, input logic [31:0] off);
        logic [31:0] r;
        bus_wr(10'h10, off);
        bus_rd(10'h11, r);
        chk(tag, r, exp_win(off));
    endtask

    logic [31:0] rv;
    logic [31:0] offs [16] = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30, 32'h34,
                               32'h40, 32'h44, 32'h4C, 32'h80, 32'h94, 32'h98, 32'h98,
                               32'h04, 32'h20};

    initial begin
        void'($urandom(32'd20240611));
        m_ptr = 0; m_ear = 0; m_cfg = 32'h0080_0000; m_stat = 0;
        m_rfsh = 32'h05F0_0000; m_pwr = 32'h07C0_0000; m_ecfg = 0; m_eesr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 reset state
        bus_rd(10'h10, rv); chk("R13 pointer reset", rv, 32'h0);
        chk("R13 irq reset", {31'b0, ecc_irq}, 32'h0);
        chk("R13 enable reset", {31'b0, mem_enable}, 32'h0);
        win_check("R13 error address reset", 32'h10);
        win_check("R13 status reset", 32'h24);
        win_check("R5 cfg reset", 32'h20);
        win_check("R9 refresh reset", 32'h30);
        win_check("R10 power reset", 32'h34);

        // R1 pointer readback
        bus_wr(10'h10, 32'hDEAD_0123);
        bus_rd(10'h10, rv); chk("R1 pointer readback", rv, 32'hDEAD_0123);
        // R11 unmapped pointer value
        bus_rd(10'h11, rv); chk("R11 unmapped read", rv, 32'hFFFF_FFFF);

        // R2 other bus numbers
        bus_wr(10'h10, 32'h10);
        bus_wr(10'h12, 32'h5555_AAAA);
        bus_rd(10'h12, rv); chk("R2 other number reads zero", rv, 32'h0);
        bus_rd(10'h10, rv); chk("R2 pointer untouched", rv, 32'h10);
        bus_rd(10'h11, rv); chk("R2 error address untouched", rv, 32'h0);

        // R4 error address
        bus_wr(10'h11, 32'h1234_5678);
        bus_rd(10'h11, rv); chk("R4 error address", rv, 32'h1234_5678);

        // R3 write-one-to-clear
        bus_wr(10'h10, 32'h00); bus_wr(10'h11, 32'hFFFF_FFFF);
        bus_rd(10'h11, rv); chk("R3 error status A", rv, 32'h0);
        bus_wr(10'h10, 32'h08); bus_wr(10'h11, 32'hFFFF_FFFF);
        bus_rd(10'h11, rv); chk("R3 error status B", rv, 32'h0);

        // R11 timing
        bus_wr(10'h10, 32'h80); bus_wr(10'h11, 32'h0);
        bus_rd(10'h11, rv); chk("R11 timing all ones", rv, 32'hFFFF_FFFF);

        // R5 R6 R7 configuration edges
        bus_wr(10'h10, 32'h20); bus_wr(10'h11, 32'hC01F_FFFF);
        bus_rd(10'h11, rv); chk("R5 cfg mask", rv, 32'hC000_0000);
        chk("R6 enable after T_ENABLE", {31'b0, mem_enable}, 32'h1);
        win_check("R7 status30 set, R6 status31 clear", 32'h24);
        bus_wr(10'h10, 32'h20); bus_wr(10'h11, 32'h8000_0000);
        chk("R6 enable held", {31'b0, mem_enable}, 32'h1);
        win_check("R7 status30 cleared", 32'h24);
        bus_wr(10'h10, 32'h20); bus_wr(10'h11, 32'h0000_0000);
        chk("R6 enable after T_DISABLE", {31'b0, mem_enable}, 32'h0);
        win_check("R6 status31 set", 32'h24);

        // R8 status read-only
        bus_wr(10'h10, 32'h24); bus_wr(10'h11, 32'h0000_0000);
        bus_rd(10'h11, rv); chk("R8 status read-only", rv, 32'h8000_0000);

        // R9 R10 masks
        bus_wr(10'h10, 32'h30); bus_wr(10'h11, 32'hFFFF_FFFF);
        bus_rd(10'h11, rv); chk("R9 refresh mask", rv, 32'h3FF8_0000);
        bus_wr(10'h10, 32'h94); bus_wr(10'h11, 32'hFFFF_FFFF);
        bus_rd(10'h11, rv); chk("R9 ECC cfg mask", rv, 32'h00F0_0000);
        bus_wr(10'h10, 32'h34); bus_wr(10'h11, 32'h0000_0000);
        bus_rd(10'h11, rv); chk("R10 power forced bits", rv, 32'h07C0_0000);
        bus_wr(10'h11, 32'hFFFF_FFFF);
        bus_rd(10'h11, rv); chk("R10 power mask", rv, 32'hFFC0_0000);

        // R12 interrupt
        bus_wr(10'h10, 32'h98); bus_wr(10'h11, 32'h000F_0FFF);
        chk("R12 masked-out bits keep irq low", {31'b0, ecc_irq}, 32'h0);
        bus_wr(10'h11, 32'h0000_1000);
        chk("R12 irq rises", {31'b0, ecc_irq}, 32'h1);
        bus_rd(10'h11, rv); chk("R12 ECC status value", rv, 32'h0000_1000);
        bus_wr(10'h11, 32'h0);
        chk("R12 irq falls", {31'b0, ecc_irq}, 32'h0);

        // R14 bank forwarding
        bus_wr(10'h10, 32'h48);
        @(negedge clk);
        bus_num = 10'h11; bus_wdata = 32'hCAFE_F00D; bus_we = 1'b1;
        #1;
        chk("R14 bank strobe", {31'b0, bank_we}, 32'h1);
        chk("R14 bank index", {30'b0, bank_idx}, 32'h2);
        chk("R14 bank data", bank_wdata, 32'hCAFE_F00D);
        @(negedge clk); bus_we = 1'b0;
        #1 chk("R14 strobe one cycle", {31'b0, bank_we}, 32'h0);
        bus_rd(10'h11, rv); chk("R14 bank read", rv, 32'hB000_0002);

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [31:0] off, val;
            off = offs[$urandom_range(0, 15)];
            val = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
            bus_wr(10'h10, off);
            bus_wr(10'h11, val);
            bus_rd(10'h11, rv);
            chk("R5-R12 random window readback", rv, exp_win(off));
            chk("R12 random irq", {31'b0, ecc_irq}, {31'b0, (m_eesr != 0)});
            chk("R6 random enable", {31'b0, mem_enable}, {31'b0, m_cfg[31]});
        end
        win_check("R7 final status", 32'h24);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule